// File: doc/BRIEF.md
# Double-Data-Rate Write Capture with Byte Masking

This block sits between the pads of a double-data-rate memory data path and the array-side write port. Write beats arrive on a 16-bit data bus as two beats per clock: one on the rising edge of a per-byte-lane strobe, one on its falling edge. A mask bit per lane is sampled with each beat. The block joins each rising and falling beat into one 32-bit prefetch word and turns the mask bits into four byte enables. It also tracks how many words the burst holds and advances the column address once per word.

A write command (`wr_go` with `wr_col` and `bl_code`) starts a burst. The pairs that belong to it are strobed in the clock cycles after the command, one pair per cycle. When a new command arrives while a burst is running, the pair strobed in that cycle closes the old burst, and the next cycle's pair is the first word of the new burst at the new column. Strobe activity outside a write burst, such as during reads or idle cycles, produces nothing.

Top module: `ddr_wr_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `word_valid`, `wr_done`, `word_be`, `word_data` and `word_col` are all zero.
- R2: In each word, bits [15:0] hold the beat sampled on the strobe rising edge and bits [31:16] hold the beat sampled on the falling edge of the same strobe pulse.
- R3: Strobe and mask bit 0 cover data bits [7:0]; strobe and mask bit 1 cover data bits [15:8]. Each 8-bit field of a word comes from its own lane.
- R4: `word_be` bit 0 is the inverse of the lower-lane rising mask, bit 1 of the upper-lane rising mask, bit 2 of the lower-lane falling mask and bit 3 of the upper-lane falling mask (mask high blocks the byte). `word_be` is zero in every cycle where `word_valid` is low.
- R5: `bl_code` 0 selects 2 beats (1 word), 1 selects 4 beats (2 words), and 2 or 3 select 8 beats (4 words). An uninterrupted burst issues exactly that many words.
- R6: The first word of a burst carries `wr_col`. Each following word carries the previous column plus one, wrapping modulo 2^10.
- R7: `wr_done` is high for one cycle, in the cycle after the last word of a burst is issued.
- R8: A command that arrives during a burst makes the pair strobed in that cycle the last word of the old burst. The word after it is the first word of the new burst.
- R9: Strobe edges, data and mask values outside a write burst produce no word: `word_valid` stays low.
- R10: A pair strobed in the cycle that follows a command, or in any later cycle of the burst, appears on the outputs one clock edge after the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq | input | 16 | Write data bus, two beats per clock |
| dqs | input | 2 | Per-lane data strobes (bit 0 lower byte, bit 1 upper byte) |
| dm | input | 2 | Per-lane write masks, sampled on both strobe edges |
| wr_go | input | 1 | Write command strobe, sampled on the clock |
| wr_col | input | 10 | Starting column of the commanded burst |
| bl_code | input | 2 | Burst length select |
| word_data | output | 32 | Assembled prefetch word |
| word_be | output | 4 | Byte enables for the prefetch word |
| word_col | output | 10 | Column of the prefetch word |
| word_valid | output | 1 | A prefetch word is presented this cycle |
| wr_done | output | 1 | Burst finished (one cycle after its last word) |

## Verification
Directed bursts of every length begin near the top of the column range, so the column wrap shows up. These bursts use mask patterns that differ per lane and per beat, which separates a swapped lane from a swapped beat half or an inverted enable. A long random phase mixes back-to-back commands, commands during a burst at any pair index, and idle cycles. In the idle cycles the strobes toggle with unrelated data, which shows that truncation, restart and read-time strobes each behave as required. A bench model predicts every output in every cycle, so a word that is missing, extra or shifted by one cycle is caught, along with a wrong value.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
   localparam int unsigned BL_CODE_W    = 2;
   localparam int unsigned MAX_WORD_LOG = 2;
   localparam int unsigned CNT_W        = MAX_WORD_LOG + 1;

   // prefetch words per burst for a burst-length code (codes above the max saturate)
   function automatic logic [CNT_W-1:0] words_for(input logic [BL_CODE_W-1:0] code);
      if (int'(code) > int'(MAX_WORD_LOG))
         return CNT_W'(1) << MAX_WORD_LOG;
      else
         return CNT_W'(1) << code;
   endfunction
endpackage

// File: rtl/wcap_lane.sv
module wcap_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              dqs,
   input  logic [LANE_W-1:0] dq,
   input  logic              dm,
   output logic [LANE_W-1:0] rise_dq,
   output logic              rise_dm,
   output logic [LANE_W-1:0] fall_dq,
   output logic              fall_dm
);
   // even beat on the strobe's rising edge
   always_ff @(posedge dqs) begin
      rise_dq <= dq;
      rise_dm <= dm;
   end

   // odd beat on the strobe's falling edge
   always_ff @(negedge dqs) begin
      fall_dq <= dq;
      fall_dm <= dm;
   end
endmodule

// File: rtl/wcap_seq.sv
module wcap_seq
   import wcap_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [COL_W-1:0]     col_in,
   input  logic [BL_CODE_W-1:0] bl_code,
   output logic                 take,
   output logic                 last,
   output logic [COL_W-1:0]     col
);
   localparam logic [CNT_W-1:0] MAX_WORDS = CNT_W'(1) << MAX_WORD_LOG;

   logic             busy_q;
   logic [CNT_W-1:0] left_q;
   logic [COL_W-1:0] col_q;

   assign take = busy_q;
   assign last = busy_q & ((left_q == CNT_W'(1)) | go);
   assign col  = col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
         col_q  <= '0;
      end else if (go) begin
         busy_q <= 1'b1;
         col_q  <= col_in;
         left_q <= words_for(bl_code);
      end else if (busy_q) begin
         col_q  <= col_q + COL_W'(1);
         left_q <= left_q - CNT_W'(1);
         if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end
   end

   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (busy_q && col_q == $past(col_in)));                           // R8
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !go && left_q != CNT_W'(1)) |=> (col_q == $past(col_q) + COL_W'(1))); // R6
   AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q != '0 && left_q <= MAX_WORDS));                    // R5
endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
   import wcap_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 2,
   parameter int unsigned COL_W  = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LANE_W*LANES-1:0]       dq,
   input  logic [LANES-1:0]              dqs,
   input  logic [LANES-1:0]              dm,
   input  logic                          wr_go,
   input  logic [COL_W-1:0]              wr_col,
   input  logic [BL_CODE_W-1:0]          bl_code,
   output logic [2*LANE_W*LANES-1:0]     word_data,
   output logic [2*LANES-1:0]            word_be,
   output logic [COL_W-1:0]              word_col,
   output logic                          word_valid,
   output logic                          wr_done
);
   localparam int unsigned BUS_W  = LANE_W * LANES;
   localparam int unsigned WORD_W = 2 * BUS_W;
   localparam int unsigned BE_W   = 2 * LANES;

   generate
      if (LANE_W < 1 || LANES < 1 || COL_W < 2) begin : g_bad_cfg
         $error("ddr_wr_capture: LANE_W, LANES must be >= 1 and COL_W >= 2");
      end
   endgenerate

   logic [BUS_W-1:0] rise_bus, fall_bus;
   logic [LANES-1:0] rise_msk, fall_msk;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      wcap_lane #(.LANE_W(LANE_W)) u_lane (
         .dqs     (dqs[g]),
         .dq      (dq[g*LANE_W +: LANE_W]),
         .dm      (dm[g]),
         .rise_dq (rise_bus[g*LANE_W +: LANE_W]),
         .rise_dm (rise_msk[g]),
         .fall_dq (fall_bus[g*LANE_W +: LANE_W]),
         .fall_dm (fall_msk[g])
      );
   end

   logic             take, last;
   logic [COL_W-1:0] seq_col;

   wcap_seq #(.COL_W(COL_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (wr_go),
      .col_in  (wr_col),
      .bl_code (bl_code),
      .take    (take),
      .last    (last),
      .col     (seq_col)
   );

   logic word_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_data   <= '0;
         word_be     <= '0;
         word_col    <= '0;
         word_valid  <= 1'b0;
         word_last_q <= 1'b0;
         wr_done     <= 1'b0;
      end else begin
         word_valid  <= take;
         word_last_q <= take & last;
         wr_done     <= word_last_q;
         if (take) begin
            word_data <= {fall_bus, rise_bus};
            word_be   <= ~{fall_msk, rise_msk};
            word_col  <= seq_col;
         end else begin
            word_be   <= '0;
         end
      end
   end

   AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> $past(word_valid));                                       // R7
   AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !word_valid);                                               // R9
   AST_BE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> (word_be == '0));                                     // R4
   AST_WORD_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (word_valid && word_col == $past(seq_col)));                 // R10
endmodule

// File: tb/ddr_wr_capture_bench.sv
`timescale 1ns/1ps
module ddr_wr_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dq = '0;
   logic [1:0]  dqs = '0;
   logic [1:0]  dm = '0;
   logic        wr_go = 1'b0;
   logic [9:0]  wr_col = '0;
   logic [1:0]  bl_code = '0;
   logic [31:0] word_data;
   logic [3:0]  word_be;
   logic [9:0]  word_col;
   logic        word_valid;
   logic        wr_done;

   always #2.5 clk = ~clk;

   ddr_wr_capture u_ddr_wr_capture (
      .clk(clk), .rst_n(rst_n), .dq(dq), .dqs(dqs), .dm(dm),
      .wr_go(wr_go), .wr_col(wr_col), .bl_code(bl_code),
      .word_data(word_data), .word_be(word_be), .word_col(word_col),
      .word_valid(word_valid), .wr_done(wr_done)
   );

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   // bench model state
   bit         m_busy = 1'b0;
   int         m_left = 0;
   logic [9:0] m_col = '0;
   bit         e_valid = 1'b0, e_last = 1'b0, e_done = 1'b0;
   logic [31:0] e_data = '0;
   logic [3:0]  e_be = '0;
   logic [9:0]  e_col = '0;

   function automatic int words_of(input logic [1:0] code);
      if (code == 2'd0) return 1;
      if (code == 2'd1) return 2;
      return 4;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   task automatic compare_outputs();
      check(word_valid == e_valid, "R5/R8/R9/R10 word_valid", 32'(word_valid), 32'(e_valid));
      check(wr_done == e_done, "R7 wr_done", 32'(wr_done), 32'(e_done));
      check(word_be == (e_valid ? e_be : 4'h0), "R4 word_be", 32'(word_be), 32'(e_valid ? e_be : 4'h0));
      if (e_valid && word_valid) begin
         check(word_data[15:0] == e_data[15:0], "R2/R3 rising beat", 32'(word_data[15:0]), 32'(e_data[15:0]));
         check(word_data[31:16] == e_data[31:16], "R2/R3 falling beat", 32'(word_data[31:16]), 32'(e_data[31:16]));
         check(word_col == e_col, "R6 word_col", 32'(word_col), 32'(e_col));
      end
   endtask

   // one clock cycle: entered and left at posedge + 0.5 ns
   task automatic step(input bit go, input logic [9:0] col, input logic [1:0] bl, input bit strobe,
                       input logic [15:0] rd, input logic [1:0] rm,
                       input logic [15:0] fd, input logic [1:0] fm);
      bit nl;
      compare_outputs();
      wr_go = go; wr_col = col; bl_code = bl;
      dq = rd; dm = rm;
      #0.75 dqs = strobe ? 2'b11 : 2'b00;
      #0.75 dq = fd; dm = fm;
      #1.75 dqs = 2'b00;
      nl = m_busy && (m_left == 1 || go);
      e_valid = m_busy;
      if (m_busy) begin
         e_data = {fd, rd};
         e_be = ~{fm, rm};
         e_col = m_col;
      end
      e_done = e_last;
      e_last = nl;
      if (go) begin
         m_busy = 1'b1; m_col = col; m_left = words_of(bl);
      end else if (m_busy) begin
         m_col = m_col + 10'd1; m_left--;
         if (m_left == 0) m_busy = 1'b0;
      end
      @(posedge clk); #0.5;
      wr_go = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] rd, fd;
      logic [1:0]  rm, fm;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #0.5;
      // R1: reset values while held and after release
      check(word_valid == 1'b0 && wr_done == 1'b0, "R1 flags in reset", {30'd0, word_valid, wr_done}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #0.5;
      check(word_be == 4'h0 && word_data == 32'd0 && word_col == 10'd0, "R1 outputs after reset",
            word_data ^ 32'(word_be) ^ 32'(word_col), 32'd0);

      // R9: strobes toggling with no write burst
      for (int i = 0; i < 4; i++)
         step(1'b0, 10'd0, 2'd0, 1'b1, 16'(i * 16'h1111), 2'(i), 16'hBEEF, 2'b00);

      // directed: each burst length from near the top of the column range (R5, R6, R4, R3)
      for (int code = 0; code < 4; code++) begin
         step(1'b1, 10'd1022, 2'(code), 1'b0, '0, '0, '0, '0);
         for (int p = 0; p < words_of(2'(code)); p++)
            step(1'b0, 10'd0, 2'd0, 1'b1, {8'hA0 + 8'(p), 8'h50 + 8'(p)}, 2'(p),
                 {8'hC0 + 8'(p), 8'h30 + 8'(p)}, 2'(3 - p));
         step(1'b0, 10'd0, 2'd0, 1'b0, '0, '0, '0, '0);
         step(1'b0, 10'd0, 2'd0, 1'b0, '0, '0, '0, '0);
      end

      // R8: new command during the second pair of an 8-beat burst
      step(1'b1, 10'd100, 2'd2, 1'b0, '0, '0, '0, '0);
      step(1'b0, 10'd0, 2'd0, 1'b1, 16'h1234, 2'b01, 16'h5678, 2'b10);
      step(1'b1, 10'd500, 2'd1, 1'b1, 16'h9ABC, 2'b00, 16'hDEF0, 2'b11);
      step(1'b0, 10'd0, 2'd0, 1'b1, 16'h0F0F, 2'b10, 16'hF0F0, 2'b01);
      step(1'b0, 10'd0, 2'd0, 1'b1, 16'h3C3C, 2'b00, 16'hC3C3, 2'b00);
      step(1'b0, 10'd0, 2'd0, 1'b0, '0, '0, '0, '0);
      step(1'b0, 10'd0, 2'd0, 1'b0, '0, '0, '0, '0);

      // random phase: back-to-back, interrupted and idle-strobe traffic (R2..R10)
      for (int n = 0; n < 3000; n++) begin
         bit go, st;
         go = m_busy ? (($urandom % 8) == 0) : (($urandom % 3) == 0);
         st = m_busy ? 1'b1 : 1'(($urandom % 2));
         rd = 16'($urandom); fd = 16'($urandom);
         rm = 2'($urandom); fm = 2'($urandom);
         step(go, 10'($urandom), 2'($urandom), st, rd, rm, fd, fm);
      end
      for (int i = 0; i < 6; i++)
         step(1'b0, 10'd0, 2'd0, 1'b0, '0, '0, '0, '0);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule